// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block holds the per-processor interrupt state for a space of 256 vectors. Each vector has three bits: one in a request-pending set, one in an in-service set and one in a trigger-kind set. A delivery port places a vector in the request-pending set and records whether it is level or edge triggered. The controller finds the highest pending vector and compares it, one 16-vector class at a time, against a processor priority. That priority is formed from the task-priority input and the highest vector in service. From this comparison it drives a registered interrupt-pending flag.

The processor claims an interrupt with a one-cycle acknowledge strobe. One cycle later the block reports one of three results: the claimed vector, a spurious vector (when the task priority masks the request), or "none" (when nothing is pending or the controller is disabled). A claimed vector moves from the request set to the in-service set. An end-of-interrupt strobe retires the highest in-service vector. Any of the three sets can be read one 32-bit word at a time.

Top module: `intpri_ctl`

## Requirements
- R1: A synchronous reset (`rst`) or a one-cycle `init_clr` strobe clears all three vector sets. After reset, `int_pend`, `ack_done`, `ack_none`, `ack_vec` and `rd_data` are 0.
- R2: An accepted vector (`acc_valid`=1) has its pending bit set at the next clock edge. Its trigger bit is set to `acc_level` (1 = level, 0 = edge).
- R3: Readback selection is `rd_sel` 0 = pending set, 1 = in-service set, 2 = trigger set, 3 = all zeros. Word `rd_idx`=n holds vectors 32n to 32n+31, with vector 32n+b in bit b. `rd_data` is registered, so it shows the word selected in the previous cycle.
- R4: The highest pending vector is the largest vector number whose pending bit is set. This is the vector an acknowledge claims.
- R5: The processor priority is computed as follows. Take the task-priority class `tpr[7:4]` and the class of the highest in-service vector (0 when none is in service). If the task-priority class is greater than or equal to the in-service class, the priority is the full `tpr` value. Otherwise it is the in-service class followed by four zero bits. The pending condition is met when some pending bit is set and either the priority is 0 or the class of the highest pending vector is strictly greater than the priority class.
- R6: While `sw_en`=0, `int_pend` is 0 and an acknowledge reports "none" (`ack_none`=1, `ack_vec`=0) without changing any state.
- R7: If `tpr`≠0 and the highest pending vector is less than or equal to `tpr`, an acknowledge returns `spur_vec` with `ack_none`=0 and changes no vector state.
- R8: Any other acknowledge with a pending vector clears that vector's pending bit, sets its in-service bit and returns it in `ack_vec` with `ack_none`=0. All acknowledge results appear, with `ack_done`=1, one cycle after `ack_req`.
- R9: `eoi` clears the highest set in-service bit. With the in-service set empty it changes nothing.
- R10: An accept and an acknowledge in the same cycle both take effect. The acknowledge works on the state before the edge. The accepted bit is set afterwards, so re-accepting the claimed vector leaves it pending and in service.
- R11: `int_pend` is registered. It reflects the vector sets one clock edge after they change, and `tpr`/`sw_en` one edge after those inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_clr | input | 1 | Clears all vector sets |
| acc_valid | input | 1 | Accept a vector this cycle |
| acc_vec | input | 8 | Vector being accepted |
| acc_level | input | 1 | Trigger kind of the accepted vector, 1 = level |
| ack_req | input | 1 | Acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr | input | 8 | Task priority |
| sw_en | input | 1 | Software enable |
| spur_vec | input | 8 | Vector returned for a masked acknowledge |
| rd_sel | input | 2 | Set to read back |
| rd_idx | input | 3 | 32-bit word index to read back |
| int_pend | output | 1 | Interrupt pending flag |
| ack_done | output | 1 | Acknowledge result valid |
| ack_none | output | 1 | Acknowledge found nothing to deliver |
| ack_vec | output | 8 | Acknowledged or spurious vector |
| rd_data | output | 32 | Readback word |

## Verification
The bench first accepts every vector in ascending order, with the trigger kind changing along the way. It then claims them all one by one and retires them all, so every bit of every word is set and cleared. The claim order separates a correct top-down search from a search that favours the wrong word or the wrong bit. After the requests are re-filled, draining the in-service set lets the pending flag switch on at exactly the class boundary. A second sweep covers every combination of task-priority class, in-service class (including none) and pending class, with a task-priority low nibble that sometimes equals the pending vector. This separates the greater-or-equal rule from a strict comparison, and the full-TPR priority from a class-only one. Directed cases cover the disabled state, same-cycle accept and claim (including the same vector), the one-edge delay of the flag, an end-of-interrupt with nothing in service, and reset in the middle of a run.

// File: rtl/intpri_pkg.sv
package intpri_pkg;
  // Readback source select encoding
  typedef enum logic [1:0] {
    SEL_PEND  = 2'd0,
    SEL_SERV  = 2'd1,
    SEL_TRIG  = 2'd2,
    SEL_ZERO  = 2'd3
  } rd_src_e;

  // Vectors share a priority class in groups of 2**CLASS_LSB
  localparam int CLASS_LSB = 4;
endpackage

// File: rtl/intpri_msb_find.sv
module intpri_msb_find #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Highest set bit wins: later iterations override earlier ones
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (bits[i]) idx = IW'(i);
    end
  end

  assign found = |bits;
endmodule

// File: rtl/intpri_scan.sv
module intpri_scan #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int NUM_WORDS = NUM_VEC / WORD_W,
  localparam int BIT_W     = $clog2(WORD_W),
  localparam int WSEL_W    = $clog2(NUM_WORDS),
  localparam int VEC_W     = WSEL_W + BIT_W
) (
  input  logic [NUM_VEC-1:0] vec,
  output logic               found,
  output logic [VEC_W-1:0]   idx
);
  logic [NUM_WORDS-1:0] word_hit;
  logic [BIT_W-1:0]     word_pos [NUM_WORDS];
  logic [WSEL_W-1:0]    word_sel;

  // First level: one encoder per word
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    intpri_msb_find #(.W(WORD_W), .IW(BIT_W)) u_word (
      .bits  (vec[w*WORD_W +: WORD_W]),
      .found (word_hit[w]),
      .idx   (word_pos[w])
    );
  end

  // Second level: highest non-empty word
  intpri_msb_find #(.W(NUM_WORDS), .IW(WSEL_W)) u_top (
    .bits  (word_hit),
    .found (found),
    .idx   (word_sel)
  );

  assign idx = {word_sel, word_pos[word_sel]};
endmodule

// File: rtl/intpri_ctl.sv
module intpri_ctl
  import intpri_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int VEC_W     = $clog2(NUM_VEC),
  localparam int NUM_WORDS = NUM_VEC / WORD_W,
  localparam int WSEL_W    = $clog2(NUM_WORDS),
  localparam int BIT_W     = $clog2(WORD_W),
  localparam int CLS_W     = VEC_W - CLASS_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_clr,
  input  logic              acc_valid,
  input  logic [VEC_W-1:0]  acc_vec,
  input  logic              acc_level,
  input  logic              ack_req,
  input  logic              eoi,
  input  logic [VEC_W-1:0]  tpr,
  input  logic              sw_en,
  input  logic [VEC_W-1:0]  spur_vec,
  input  logic [1:0]        rd_sel,
  input  logic [WSEL_W-1:0] rd_idx,
  output logic              int_pend,
  output logic              ack_done,
  output logic              ack_none,
  output logic [VEC_W-1:0]  ack_vec,
  output logic [WORD_W-1:0] rd_data
);
  logic [NUM_VEC-1:0] pend_q, serv_q, trig_q;
  logic [NUM_VEC-1:0] pend_d, serv_d, trig_d;

  logic             pend_found, serv_found;
  logic [VEC_W-1:0] pend_top, serv_top;

  intpri_scan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_scan_pend (
    .vec (pend_q), .found (pend_found), .idx (pend_top)
  );
  intpri_scan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_scan_serv (
    .vec (serv_q), .found (serv_found), .idx (serv_top)
  );

  // Processor priority from task priority and in-service class
  logic [CLS_W-1:0] tpr_cls, serv_cls;
  logic [VEC_W-1:0] proc_pri;
  logic             flag_d;

  assign tpr_cls  = tpr[VEC_W-1:CLASS_LSB];
  assign serv_cls = serv_found ? serv_top[VEC_W-1:CLASS_LSB] : '0;
  assign proc_pri = (tpr_cls >= serv_cls) ? tpr : {serv_cls, {CLASS_LSB{1'b0}}};
  assign flag_d   = sw_en && pend_found &&
                    !((proc_pri != '0) &&
                      (pend_top[VEC_W-1:CLASS_LSB] <= proc_pri[VEC_W-1:CLASS_LSB]));

  // Acknowledge decision
  logic ack_live, ack_masked, ack_take, eoi_hit;
  assign ack_live   = ack_req && sw_en && pend_found;
  assign ack_masked = (tpr != '0) && (pend_top <= tpr);
  assign ack_take   = ack_live && !ack_masked;
  assign eoi_hit    = eoi && serv_found;

  // Next state: retire, then claim, then accept (accept wins on pending set)
  always_comb begin
    pend_d = pend_q;
    serv_d = serv_q;
    trig_d = trig_q;
    if (eoi_hit) serv_d[serv_top] = 1'b0;
    if (ack_take) begin
      pend_d[pend_top] = 1'b0;
      serv_d[pend_top] = 1'b1;
    end
    if (acc_valid) begin
      pend_d[acc_vec] = 1'b1;
      trig_d[acc_vec] = acc_level;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init_clr) begin
      pend_q <= '0;
      serv_q <= '0;
      trig_q <= '0;
    end else begin
      pend_q <= pend_d;
      serv_q <= serv_d;
      trig_q <= trig_d;
    end
  end

  // Registered outputs
  logic [VEC_W-1:0] rd_base;
  assign rd_base = {rd_idx, {BIT_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      int_pend <= 1'b0;
      ack_done <= 1'b0;
      ack_none <= 1'b0;
      ack_vec  <= '0;
      rd_data  <= '0;
    end else begin
      int_pend <= flag_d;
      ack_done <= ack_req;
      ack_none <= ack_req && !ack_live;
      ack_vec  <= ack_take ? pend_top : (ack_live ? spur_vec : '0);
      case (rd_src_e'(rd_sel))
        SEL_PEND: rd_data <= pend_q[rd_base +: WORD_W];
        SEL_SERV: rd_data <= serv_q[rd_base +: WORD_W];
        SEL_TRIG: rd_data <= trig_q[rd_base +: WORD_W];
        default:  rd_data <= '0;
      endcase
    end
  end

  // Checks
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    init_clr |=> (pend_q == '0) && (serv_q == '0) && (trig_q == '0)); // R1
  AST_ACCEPT_SETS: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !init_clr) |=> pend_q[$past(acc_vec)] &&
                                 (trig_q[$past(acc_vec)] == $past(acc_level))); // R2
  AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    !sw_en |=> !int_pend); // R6
  AST_OFF_ACK_NONE: assert property (@(posedge clk) disable iff (rst)
    (ack_req && !sw_en) |=> ack_done && ack_none && (ack_vec == '0)); // R6
  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (rst)
    (ack_live && ack_masked && !eoi && !acc_valid && !init_clr)
      |=> $stable(serv_q) && $stable(pend_q)); // R7
  AST_CLAIM_SERV: assert property (@(posedge clk) disable iff (rst)
    (ack_take && !init_clr) |=> serv_q[$past(pend_top)]); // R8
  AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (eoi && !serv_found && !ack_req && !init_clr) |=> (serv_q == '0)); // R9
endmodule

// File: tb/intpri_ctl_bench.sv
module intpri_ctl_bench;
  localparam int NV = 256;

  logic clk = 1'b0;
  logic rst = 1'b1, init_clr = 1'b0, acc_valid = 1'b0, acc_level = 1'b0;
  logic ack_req = 1'b0, eoi = 1'b0, sw_en = 1'b0;
  logic [7:0] acc_vec = '0, tpr = '0, spur_vec = 8'hA5;
  logic [1:0] rd_sel = '0;
  logic [2:0] rd_idx = '0;
  logic       int_pend, ack_done, ack_none;
  logic [7:0] ack_vec;
  logic [31:0] rd_data;

  logic [NV-1:0] m_irr = '0, m_isr = '0, m_tmr = '0;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  intpri_ctl u_intpri_ctl (
    .clk, .rst, .init_clr, .acc_valid, .acc_vec, .acc_level, .ack_req, .eoi,
    .tpr, .sw_en, .spur_vec, .rd_sel, .rd_idx,
    .int_pend, .ack_done, .ack_none, .ack_vec, .rd_data
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int hi(input logic [NV-1:0] v);
    for (int i = NV - 1; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic m_pend();
    int ih, sh, sc, tc;
    logic [7:0] ppr;
    ih = hi(m_irr);
    if (!sw_en || ih < 0) return 1'b0;
    sh = hi(m_isr);
    sc = (sh < 0) ? 0 : sh / 16;
    tc = int'(tpr) / 16;
    ppr = (tc >= sc) ? tpr : 8'(sc * 16);
    return !((ppr != 0) && (ih / 16 <= int'(ppr) / 16));
  endfunction

  task automatic do_accept(input int v, input logic lvl);
    acc_valid = 1'b1; acc_vec = 8'(v); acc_level = lvl;
    tick();
    acc_valid = 1'b0;
    m_irr[v] = 1'b1;
    m_tmr[v] = lvl;
  endtask

  // Acknowledge, optionally with an accept in the same cycle
  task automatic do_ack(input string tag, input logic with_acc, input int av);
    int ih;
    logic xnone;
    logic [7:0] xvec;
    logic take;
    ih = hi(m_irr);
    take = 1'b0;
    if (!sw_en || ih < 0) begin xnone = 1'b1; xvec = 8'h00; end
    else if (tpr != 0 && ih <= int'(tpr)) begin xnone = 1'b0; xvec = spur_vec; end
    else begin xnone = 1'b0; xvec = 8'(ih); take = 1'b1; end
    ack_req = 1'b1;
    if (with_acc) begin acc_valid = 1'b1; acc_vec = 8'(av); acc_level = 1'b1; end
    tick();
    ack_req = 1'b0; acc_valid = 1'b0;
    chk({tag, " done"}, 32'(ack_done), 32'd1);
    chk({tag, " none"}, 32'(ack_none), 32'(xnone));
    chk({tag, " vec"}, 32'(ack_vec), 32'(xvec));
    if (take) begin m_irr[ih] = 1'b0; m_isr[ih] = 1'b1; end
    if (with_acc) begin m_irr[av] = 1'b1; m_tmr[av] = 1'b1; end
  endtask

  task automatic do_eoi();
    int sh;
    sh = hi(m_isr);
    eoi = 1'b1;
    tick();
    eoi = 1'b0;
    if (sh >= 0) m_isr[sh] = 1'b0;
  endtask

  task automatic do_init();
    init_clr = 1'b1;
    tick();
    init_clr = 1'b0;
    m_irr = '0; m_isr = '0; m_tmr = '0;
  endtask

  task automatic chk_pend(input string tag);
    tick();
    chk(tag, 32'(int_pend), 32'(m_pend()));
  endtask

  task automatic chk_word(input string tag, input int s, input int i);
    logic [NV-1:0] src;
    src = (s == 0) ? m_irr : ((s == 1) ? m_isr : m_tmr);
    rd_sel = 2'(s); rd_idx = 3'(i);
    tick();
    chk(tag, rd_data, src[i*32 +: 32]);
  endtask

  task automatic chk_words(input string tag);
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < 8; i++) chk_word(tag, s, i);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 pend after reset", 32'(int_pend), 32'd0);
    chk("R1 ack_done after reset", 32'(ack_done), 32'd0);
    chk("R1 ack_vec after reset", 32'(ack_vec), 32'd0);
    chk("R1 rd_data after reset", rd_data, 32'd0);
    rst = 1'b0;
    chk_words("R1 words after reset");

    // R2 R3 R5: accept every vector
    sw_en = 1'b1; tpr = 8'h00;
    for (int v = 0; v < NV; v++) begin
      do_accept(v, (v % 3) == 0);
      chk_pend("R5 pend while accepting");
    end
    chk_words("R2 R3 words after accepting all");
    rd_sel = 2'd3; rd_idx = 3'd5;
    tick();
    chk("R3 zero select", rd_data, 32'd0);

    // R4 R8 R5: claim all in priority order
    for (int k = 0; k < NV; k++) begin
      do_ack("R4 R8 claim order", 1'b0, 0);
      chk_pend("R5 pend while claiming");
    end
    chk_words("R8 words after claiming all");

    // R9 R5: refill requests, then drain in-service
    for (int v = 0; v < NV; v++) do_accept(v, 1'b0);
    for (int k = 0; k < NV; k++) begin
      do_eoi();
      chk_pend("R9 R5 pend while retiring");
    end
    chk_words("R9 words after retiring all");
    do_eoi();
    chk_words("R9 eoi on empty in-service");

    // R1: init clears
    do_init();
    chk_words("R1 words after init");

    // R5 R7 R8: class sweep
    for (int t = 0; t < 16; t++)
      for (int s = 0; s <= 16; s++)
        for (int c = 0; c < 16; c++) begin
          int v;
          do_init();
          tpr = 8'h00;
          if (s < 16) begin
            do_accept(s * 16 + 3, 1'b0);
            do_ack("R8 setup claim", 1'b0, 0);
          end
          tpr = 8'(t * 16 + (s % 3) * 5);
          v = c * 16 + 5;
          do_accept(v, 1'b1);
          chk_pend("R5 class sweep pend");
          do_ack("R7 R8 class sweep ack", 1'b0, 0);
          chk_word("R7 R8 class sweep in-service", 1, v / 32);
          chk_word("R7 R8 class sweep pending", 0, v / 32);
        end

    // R6: disabled
    do_init();
    tpr = 8'h00;
    do_accept(77, 1'b0);
    sw_en = 1'b0;
    chk_pend("R6 pend while disabled");
    do_ack("R6 ack while disabled", 1'b0, 0);
    chk_word("R6 pending kept", 0, 2);
    chk_word("R6 in-service kept", 1, 2);
    sw_en = 1'b1;
    chk_pend("R6 pend after enable");

    // R10: accept and claim together
    do_init();
    do_accept(40, 1'b0);
    do_ack("R10 claim with accept", 1'b1, 200);
    chk_words("R10 words after combined cycle");
    chk_pend("R10 pend after combined cycle");
    do_init();
    do_accept(90, 1'b0);
    do_ack("R10 claim and re-accept same", 1'b1, 90);
    chk_words("R10 words same vector");
    chk_pend("R10 pend same vector");

    // R11: flag lags state by one edge
    do_init();
    tick();
    do_accept(10, 1'b0);
    chk("R11 flag not yet raised", 32'(int_pend), 32'd0);
    chk_pend("R11 flag raised one edge later");
    sw_en = 1'b0;
    chk("R11 flag before enable edge", 32'(int_pend), 32'd1);
    chk_pend("R11 flag after enable edge");
    sw_en = 1'b1;

    // R1: reset mid-run
    do_accept(150, 1'b1);
    do_ack("R1 claim before reset", 1'b0, 0);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    m_irr = '0; m_isr = '0; m_tmr = '0;
    chk("R1 pend after mid reset", 32'(int_pend), 32'd0);
    chk_words("R1 words after mid reset");

    summary();
    $finish;
  end
endmodule